// File: doc/BRIEF.md
# Prescaled Real-Time Counter with Compare Channels

This peripheral keeps a free-running 24-bit count of slow time. A low-frequency tick-enable input feeds a 12-bit divider: while the counter runs, it advances once every PRESCALER+1 ticks. Software controls it through a small synchronous register bus. Task strobes start, stop and zero the counter, and one task preloads it close to its wrap point. Four compare registers raise a sticky flag when the counter reaches their value. Two more sticky flags mark each increment and each wrap.

Each flag can drive the shared interrupt line and a per-event routing pulse. Two separate masks gate these paths. The interrupt mask changes only through set-only and clear-only registers. The routing mask has these two registers as well as a full-write register. The routing pulses are one clock wide and are meant for event fabric elsewhere on the chip.

Top module: `rtc_cmp`

## Requirements
- R1: After reset the counter, the prescaler, the divider phase, all flags and both masks are zero, the counter is stopped, `irq` is low and no routing pulse is active.
- R2: Writing a word with bit 0 set to 0x000 starts the counter and to 0x004 stops it; while stopped the counter holds its value whatever `lf_tick` does.
- R3: While running, the counter advances on every (P+1)-th clock with `lf_tick` high, P being the prescaler (0x508, bits 11:0); a prescaler write while running is ignored.
- R4: A bit-0 write to 0x008 zeroes the counter and the divider phase; one to 0x00C loads 0xFFFFF0 into the counter; either task replaces any advance in that cycle.
- R5: The counter wraps from 0xFFFFFF to 0x000000 and the overflow flag (0x104, bit 0) is set on the same clock edge.
- R6: The tick flag (0x100, bit 0) is set on every counter advance.
- R7: Compare register n (0x540 + 4n, 24 bits, n = 0..3) sets flag n (0x140 + 4n, bit 0) on the edge where the counter advances to a value equal to it.
- R8: Flags are sticky; a write with bit 0 clear to a flag's address clears it, a write with bit 0 set leaves it alone, and an event setting a flag wins over a clearing write in the same cycle.
- R9: The interrupt mask has tick at bit 0, overflow at bit 1 and compare n at bit 16+n; ones written to 0x304 set bits, ones written to 0x308 clear them, both addresses read the mask, and `irq` is the OR of the flags whose mask bits are set.
- R10: The routing mask uses the same layout, is fully written at 0x340, set at 0x344 and cleared at 0x348, and reads back at all three; `route_pulse` (bit 0 tick, bit 1 overflow, bit 2+n compare n) is high for exactly the clock in which the matching flag is set by an event, and only if its mask bit is 1.
- R11: The counter reads at 0x504 and cannot be written there; unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lf_tick | input | 1 | Low-frequency tick enable, one clock per slow tick |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |
| route_pulse | output | 6 | Per-event routed pulses |

## Verification
Two operations can land on the same clock edge. In the first, a counter advance sets the tick flag while software writes a zero to clear that same flag. The bench provokes this by setting the prescaler to zero, holding `lf_tick` high so that the counter advances on every clock, and issuing the clearing write. The flag must still read as one afterwards. The second collision is a task write meeting a due advance, which the bench triggers with the clear and preload tasks. The reference model checks every clock that the task value wins and that no tick event appears.

// File: rtl/rtc_cmp.sv
module rtc_cmp #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 12,
  parameter int NCMP  = 4,
  parameter int AW    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lf_tick,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [NCMP+1:0]   route_pulse
);
  localparam int NEV = NCMP + 2;
  localparam logic [CNT_W-1:0] PRELOAD = ~CNT_W'(15);
  localparam logic [AW-1:0] A_START = AW'('h000), A_STOP = AW'('h004),
                            A_CLR = AW'('h008), A_FOV = AW'('h00C),
                            A_IESET = AW'('h304), A_IECLR = AW'('h308),
                            A_RE = AW'('h340), A_RESET = AW'('h344),
                            A_RECLR = AW'('h348), A_CNT = AW'('h504),
                            A_PRE = AW'('h508);

  function automatic logic [AW-1:0] flag_addr(input int k);
    return (k < 2) ? AW'('h100 + 4 * k) : AW'('h140 + 4 * (k - 2));
  endfunction

  function automatic logic [AW-1:0] cc_addr(input int n);
    return AW'('h540 + 4 * n);
  endfunction

  function automatic logic [31:0] mask_word(input logic [NEV-1:0] m);
    logic [31:0] w;
    w = '0;
    w[1:0] = m[1:0];
    for (int n = 0; n < NCMP; n++) w[16+n] = m[2+n];
    return w;
  endfunction

  logic                 running;
  logic [PRE_W-1:0]     pre, phase;
  logic [CNT_W-1:0]     cnt, cnt_inc;
  logic [CNT_W-1:0]     cc [NCMP];
  logic [NEV-1:0]       flag, ie, re, ev, route_q, wmask;
  logic                 do_start, do_stop, do_clr, do_fov, advance;

  assign do_start = bus_we && bus_addr == A_START && bus_wdata[0];
  assign do_stop  = bus_we && bus_addr == A_STOP  && bus_wdata[0];
  assign do_clr   = bus_we && bus_addr == A_CLR   && bus_wdata[0];
  assign do_fov   = bus_we && bus_addr == A_FOV   && bus_wdata[0];
  assign advance  = running && lf_tick && phase == pre && !do_clr && !do_fov;
  assign cnt_inc  = cnt + CNT_W'(1);
  assign wmask    = {bus_wdata[16 +: NCMP], bus_wdata[1:0]};

  assign ev[0] = advance;
  assign ev[1] = advance && (&cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      phase   <= '0;
      pre     <= '0;
    end else begin
      if (do_start) running <= 1'b1;
      else if (do_stop) running <= 1'b0;
      if (do_clr) begin
        cnt   <= '0;
        phase <= '0;
      end else if (do_fov) begin
        cnt   <= PRELOAD;
      end else if (running && lf_tick) begin
        if (phase == pre) begin
          phase <= '0;
          cnt   <= cnt_inc;
        end else begin
          phase <= phase + PRE_W'(1);
        end
      end
      if (bus_we && bus_addr == A_PRE && !running) pre <= bus_wdata[PRE_W-1:0];
    end
  end

  for (genvar n = 0; n < NCMP; n++) begin : g_cmp
    assign ev[2+n] = advance && cnt_inc == cc[n];
    always_ff @(posedge clk) begin
      if (!rst_n) cc[n] <= '0;
      else if (bus_we && bus_addr == cc_addr(n)) cc[n] <= bus_wdata[CNT_W-1:0];
    end
  end

  for (genvar k = 0; k < NEV; k++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flag[k] <= 1'b0;
      else if (ev[k]) flag[k] <= 1'b1;
      else if (bus_we && bus_addr == flag_addr(k) && !bus_wdata[0]) flag[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie      <= '0;
      re      <= '0;
      route_q <= '0;
    end else begin
      route_q <= ev & re;
      if (bus_we && bus_addr == A_IESET) ie <= ie | wmask;
      if (bus_we && bus_addr == A_IECLR) ie <= ie & ~wmask;
      if (bus_we && bus_addr == A_RE)    re <= wmask;
      if (bus_we && bus_addr == A_RESET) re <= re | wmask;
      if (bus_we && bus_addr == A_RECLR) re <= re & ~wmask;
    end
  end

  assign irq         = |(flag & ie);
  assign route_pulse = route_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT:                    bus_rdata[CNT_W-1:0] = cnt;
      A_PRE:                    bus_rdata[PRE_W-1:0] = pre;
      A_IESET, A_IECLR:         bus_rdata = mask_word(ie);
      A_RE, A_RESET, A_RECLR:   bus_rdata = mask_word(re);
      default: ;
    endcase
    for (int n = 0; n < NCMP; n++)
      if (bus_addr == cc_addr(n)) bus_rdata[CNT_W-1:0] = cc[n];
    for (int k = 0; k < NEV; k++)
      if (bus_addr == flag_addr(k)) bus_rdata[0] = flag[k];
  end
endmodule

// File: rtl/rtc_cmp_chk.sv
module rtc_cmp_chk #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 12,
  parameter int NCMP  = 4,
  parameter int AW    = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic              running,
  input logic [CNT_W-1:0]  cnt,
  input logic [PRE_W-1:0]  pre,
  input logic [NCMP+1:0]   flag,
  input logic [NCMP+1:0]   ie,
  input logic              irq,
  input logic [NCMP+1:0]   route_pulse
);
  logic task_wr;
  assign task_wr = bus_we && (bus_addr == AW'('h008) || bus_addr == AW'('h00C));

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !task_wr) |=> $stable(cnt));

  // R3
  pre_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(pre));

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[1]) |-> cnt == '0);

  // R6
  tick_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag[0]) |-> cnt != $past(cnt));

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ie == '0) |-> !irq);

  // R10
  for (genvar k = 0; k < NCMP + 2; k++) begin : g_rt
    route_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      route_pulse[k] |-> flag[k]);
  end
endmodule

bind rtc_cmp rtc_cmp_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W), .NCMP(NCMP), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .running(running), .cnt(cnt), .pre(pre), .flag(flag), .ie(ie),
  .irq(irq), .route_pulse(route_pulse));

// File: tb/test_rtc_cmp.sv
module test_rtc_cmp;
  logic        clk = 0, rst_n = 0, lf_tick = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [5:0]  route_pulse;
  int errors = 0, checks = 0, pulses_c1 = 0;
  bit done = 0;

  rtc_cmp i_rtc_cmp (.clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .route_pulse(route_pulse));

  always #4 clk = ~clk;

  int unsigned m_cnt, m_ph, m_pre, m_cc[4];
  bit m_run;
  bit [5:0] m_flag, m_ie, m_re, m_pulse;

  function automatic int unsigned faddr(int k);
    return (k < 2) ? 'h100 + 4 * k : 'h140 + 4 * (k - 2);
  endfunction
  function automatic bit [31:0] pack(bit [5:0] m);
    bit [31:0] w = 0;
    w[1:0] = m[1:0]; w[19:16] = m[5:2];
    return w;
  endfunction
  function automatic bit [31:0] model_read(int unsigned a);
    if (a == 'h504) return m_cnt;
    if (a == 'h508) return m_pre;
    if (a == 'h304 || a == 'h308) return pack(m_ie);
    if (a == 'h340 || a == 'h344 || a == 'h348) return pack(m_re);
    for (int n = 0; n < 4; n++) if (a == 'h540 + 4 * n) return m_cc[n];
    for (int k = 0; k < 6; k++) if (a == faddr(k)) return {31'b0, m_flag[k]};
    return 0;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit [5:0] ev;
    bit [31:0] d;
    int unsigned a, nc;
    ev = 0; a = bus_addr; d = bus_wdata;
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_pre = 0; m_run = 0; m_flag = 0; m_ie = 0; m_re = 0; m_pulse = 0;
      for (int n = 0; n < 4; n++) m_cc[n] = 0;
    end else begin
      if (bus_we && a == 'h008 && d[0]) begin m_cnt = 0; m_ph = 0; end
      else if (bus_we && a == 'h00C && d[0]) m_cnt = 'hFFFFF0;
      else if (m_run && lf_tick) begin
        if (m_ph == m_pre) begin
          nc = (m_cnt + 1) & 'hFFFFFF;
          ev[0] = 1;
          if (m_cnt == 'hFFFFFF) ev[1] = 1;
          for (int n = 0; n < 4; n++) if (nc == m_cc[n]) ev[2+n] = 1;
          m_cnt = nc; m_ph = 0;
        end else m_ph++;
      end
      m_pulse = ev & m_re;
      for (int k = 0; k < 6; k++)
        if (ev[k]) m_flag[k] = 1;
        else if (bus_we && a == faddr(k) && !d[0]) m_flag[k] = 0;
      if (bus_we && a == 'h508 && !m_run) m_pre = d & 'hFFF;
      if (bus_we && a == 'h000 && d[0]) m_run = 1;
      if (bus_we && a == 'h004 && d[0]) m_run = 0;
      for (int n = 0; n < 4; n++) if (bus_we && a == 'h540 + 4 * n) m_cc[n] = d & 'hFFFFFF;
      if (bus_we && a == 'h304) m_ie = m_ie | {d[19:16], d[1:0]};
      if (bus_we && a == 'h308) m_ie = m_ie & ~{d[19:16], d[1:0]};
      if (bus_we && a == 'h340) m_re = {d[19:16], d[1:0]};
      if (bus_we && a == 'h344) m_re = m_re | {d[19:16], d[1:0]};
      if (bus_we && a == 'h348) m_re = m_re & ~{d[19:16], d[1:0]};
    end
    #2;
    if (route_pulse[3]) pulses_c1++;
    chk(irq == |(m_flag & m_ie), "R9", "irq per cycle", irq, |(m_flag & m_ie));
    chk(route_pulse == m_pulse, "R10", "route_pulse per cycle", route_pulse, m_pulse);
    chk(bus_rdata == model_read(bus_addr), "R11", "rdata per cycle", bus_rdata, model_read(bus_addr));
  end

  task automatic wr(int unsigned a, bit [31:0] d);
    @(negedge clk); bus_addr = a[11:0]; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask
  task automatic rd(int unsigned a, bit [31:0] exp, string req);
    @(negedge clk); bus_we = 0; bus_addr = a[11:0]; #1;
    chk(bus_rdata == exp, req, $sformatf("read %0h", a), bus_rdata, exp);
  endtask
  task automatic ticks(int n);
    lf_tick = 1; repeat (n) @(negedge clk); lf_tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd('h504, 0, "R1");
    rd('h304, 0, "R1");
    #1 chk(irq == 0 && route_pulse == 0, "R1", "irq/route after reset", {irq, route_pulse}, 0);
    // R3 prescaler 2: 9 ticks -> 3 advances
    wr('h508, 2); wr('h008, 1); wr('h000, 1);
    ticks(9);
    rd('h504, 3, "R3");
    wr('h508, 7);
    rd('h508, 2, "R3");
    rd('h100, 1, "R6");
    // R9 interrupt mask
    wr('h304, 1);
    #1 chk(irq == 1, "R9", "irq with tick enabled", irq, 1);
    rd('h308, 1, "R9");
    wr('h100, 0);
    #1 chk(irq == 0, "R8", "irq after flag clear", irq, 0);
    // R7 compare 1 at 5, routed
    wr('h544, 5); wr('h340, 32'h0002_0000); wr('h304, 32'h0002_0000);
    ticks(6);
    rd('h504, 5, "R7");
    rd('h144, 1, "R7");
    chk(pulses_c1 == 1, "R10", "compare-1 pulse count", pulses_c1, 1);
    #1 chk(irq == 1, "R9", "irq from compare 1", irq, 1);
    // R2 stop holds counter
    wr('h004, 1);
    ticks(5);
    rd('h504, 5, "R2");
    wr('h508, 0);
    rd('h508, 0, "R3");
    // R4 preload, R5 wrap after 16
    wr('h00C, 1);
    rd('h504, 'hFFFFF0, "R4");
    wr('h344, 2); wr('h304, 2);
    wr('h000, 1);
    ticks(16);
    rd('h504, 0, "R5");
    rd('h104, 1, "R5");
    rd('h348, 32'h0002_0002, "R10");
    // R8 event beats clearing write
    lf_tick = 1;
    wr('h100, 0);
    rd('h100, 1, "R8");
    lf_tick = 0;
    wr('h100, 1);
    rd('h100, 1, "R8");
    wr('h004, 1);
    wr('h100, 0);
    rd('h100, 0, "R8");
    // R4 clear task, and clear beats a due advance
    wr('h000, 1);
    lf_tick = 1;
    wr('h008, 1);
    lf_tick = 0;
    rd('h504, 0, "R4");
    wr('h004, 1);
    // R10 clear-write and full write
    wr('h348, 32'h0002_0000);
    rd('h340, 2, "R10");
    wr('h340, 32'h000F_0001);
    rd('h344, 32'h000F_0001, "R10");
    // R11 counter not writable, unmapped zero
    wr('h504, 123);
    rd('h504, 0, "R11");
    rd('h700, 0, "R11");
    done = 1;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule